// File: doc/BRIEF.md
# Converter-style ready/data serial output port

This block is the digital device side of a one-wire serial port of the kind a 24-bit converter presents. A free-running conversion timer, counted in system clocks, closes one conversion every period. At the close of each period the block takes the signed sample word offered by an internal source and clamps it to the 24-bit two's-complement range. It stores the result and pulls the shared ready/data line low to announce it. A new result always replaces the previous one, whether or not the host read it.

The host reads by giving rising edges on an external serial clock. The block samples this clock with its own faster system clock through a synchronizer. Each detected rising edge puts the next result bit on the line, most significant first. The host may stop after any number of bits, and the line then keeps the level of the last bit. A 25th rising edge drives the line high, so a polling host does not mistake a stale zero for a ready flag. For a short window before each new result the line is held high, serial clock edges are ignored and the bit pointer returns to the most significant bit.

Top module: `sdadc_serial_port`

## Requirements
- R1: After reset the line is high, and serial clock edges have no effect until the first result has been stored.
- R2: A sample greater than 8388607 (0x7FFFFF) as a signed value is stored as 0x7FFFFF.
- R3: A sample less than -8388608 is stored as 0x800000; a sample inside the range is stored as its low 24 bits.
- R4: A result is stored every CONV_CYC system clocks, and the line goes low in the clock after the period closes. A result that was not read is replaced by the next one.
- R5: Each rising serial clock edge presents the next result bit on the line, bit 23 first and bit 0 on the 24th edge. The line changes three system clocks after the edge is sampled.
- R6: When the host stops before the 24th edge, the line holds the last bit shifted until the next update window.
- R7: The 25th rising edge drives the line high, and any further edges before the next result keep it high.
- R8: During the last UPD_CYC clocks of each period the line is high and serial clock edges are ignored. The high level lasts UPD_CYC-1 clocks before the line drops for the new result, and the first edge after the drop gives bit 23.
- R9: Falling serial clock edges never change the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | IN_W | Signed sample word from the internal source, taken at each period close |
| sclk_i | input | 1 | Serial clock from the host, asynchronous to clk |
| rdy_dout_o | output | 1 | Shared ready/data line, registered |

## Verification
The checker checks every cycle that both saturation bounds hold and that the line drops after each period close. It also checks that the line is high and the pointer is back at the most significant bit during the update window, that the line is high after the 25th edge, and that the line keeps its level when no edge, window or load occurs. Only the bench scenarios can show that the bits come out in the right order for random and extreme samples, and that the period length is exact. The same goes for the length of the high interval and the overwrite of an unread result. Edges given during the window and edges given before the first result are also covered by the bench alone.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;
  localparam int DEF_IN_W     = 32;
  localparam int DEF_OUT_W    = 24;
  localparam int DEF_CONV_CYC = 163840;
  localparam int DEF_UPD_CYC  = 16;
  localparam int DEF_SYNC_N   = 2;

  typedef struct packed {
    logic upd;   // inside the update window
    logic load;  // last clock of the period: store a result
  } tick_t;
endpackage

// File: rtl/sdadc_sat.sv
module sdadc_sat #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 24
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  generate
    if (IN_W > OUT_W) begin : g_clip
      localparam int HDR_W = IN_W - OUT_W + 1;
      logic [HDR_W-1:0] hdr;
      logic fits;
      assign hdr  = din[IN_W-1:OUT_W-1];
      assign fits = (hdr == {HDR_W{1'b0}}) || (hdr == {HDR_W{1'b1}});
      always_comb begin
        if (fits)                dout = din[OUT_W-1:0];
        else if (din[IN_W-1])    dout = NEG_MAX;
        else                     dout = POS_MAX;
      end
    end else begin : g_pass
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sdadc_timer.sv
module sdadc_timer
  import sdadc_pkg::*;
#(
  parameter int CONV_CYC = 163840,
  parameter int UPD_CYC  = 16
) (
  input  logic  clk,
  input  logic  rst,
  output tick_t tick
);
  localparam int CNT_W = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] WSTRT = CNT_W'(CONV_CYC - UPD_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    tick.load = (cnt_q == LAST);
    tick.upd  = (cnt_q >= WSTRT);
  end
endmodule

// File: rtl/sdadc_edge.sv
module sdadc_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  output logic rise
);
  logic [SYNC_N:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-1:0], sclk_i};
  end

  assign rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
endmodule

// File: rtl/sdadc_shift.sv
module sdadc_shift
  import sdadc_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  tick_t            tick,
  input  logic             rise,
  input  logic [OUT_W-1:0] word,
  output logic [PTR_W-1:0] ptr_o,
  output logic             line_o
);
  localparam logic [PTR_W-1:0] LAST_BIT = PTR_W'(OUT_W);
  localparam logic [PTR_W-1:0] DONE     = PTR_W'(OUT_W + 1);

  logic [OUT_W-1:0] sh_q;
  logic [PTR_W-1:0] ptr_q;
  logic             valid_q;
  logic             line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      ptr_q   <= '0;
      valid_q <= 1'b0;
      line_q  <= 1'b1;
    end else if (tick.load) begin
      sh_q    <= word;
      ptr_q   <= '0;
      valid_q <= 1'b1;
      line_q  <= 1'b0;
    end else if (tick.upd) begin
      ptr_q   <= '0;
      line_q  <= 1'b1;
    end else if (rise && valid_q) begin
      if (ptr_q < LAST_BIT) begin
        line_q <= sh_q[OUT_W-1];
        sh_q   <= {sh_q[OUT_W-2:0], 1'b0};
        ptr_q  <= ptr_q + 1'b1;
      end else if (ptr_q == LAST_BIT) begin
        line_q <= 1'b1;
        ptr_q  <= DONE;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign line_o = line_q;
endmodule

// File: rtl/sdadc_serial_port.sv
module sdadc_serial_port
  import sdadc_pkg::*;
#(
  parameter int IN_W     = DEF_IN_W,
  parameter int OUT_W    = DEF_OUT_W,
  parameter int CONV_CYC = DEF_CONV_CYC,
  parameter int UPD_CYC  = DEF_UPD_CYC,
  parameter int SYNC_N   = DEF_SYNC_N
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] sample_i,
  input  logic            sclk_i,
  output logic            rdy_dout_o
);
  localparam int PTR_W = $clog2(OUT_W + 2);

  tick_t            tick_w;
  logic             rise_w;
  logic [OUT_W-1:0] sat_w;
  logic [PTR_W-1:0] ptr_w;

  sdadc_timer #(.CONV_CYC(CONV_CYC), .UPD_CYC(UPD_CYC)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_w)
  );

  sdadc_edge #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .rise(rise_w)
  );

  sdadc_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat (
    .din(sample_i), .dout(sat_w)
  );

  sdadc_shift #(.OUT_W(OUT_W), .PTR_W(PTR_W)) u_shift (
    .clk(clk), .rst(rst), .tick(tick_w), .rise(rise_w),
    .word(sat_w), .ptr_o(ptr_w), .line_o(rdy_dout_o)
  );
endmodule

// File: rtl/sdadc_chk.sv
module sdadc_chk #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 24,
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  sample,
  input logic [OUT_W-1:0] sat,
  input logic             load,
  input logic             upd,
  input logic             rise,
  input logic [PTR_W-1:0] ptr,
  input logic             line
);
  localparam longint MAXV = (64'sd1 <<< (OUT_W - 1)) - 64'sd1;
  localparam longint MINV = -(64'sd1 <<< (OUT_W - 1));
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] s_samp;
  assign s_samp = $signed(sample);

  p_sat_hi_r2: assert property (@(posedge clk) disable iff (rst)
    (longint'(s_samp) > MAXV) |-> (sat == POS_MAX));

  p_sat_lo_r3: assert property (@(posedge clk) disable iff (rst)
    (longint'(s_samp) < MINV) |-> (sat == NEG_MAX));

  p_ready_low_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> !line);

  p_upd_high_r8: assert property (@(posedge clk) disable iff (rst)
    (upd && !load) |=> line);

  p_ptr_msb_r8: assert property (@(posedge clk) disable iff (rst)
    upd |=> (ptr == '0));

  p_extra_high_r7: assert property (@(posedge clk) disable iff (rst)
    (rise && !upd && !load && (ptr >= PTR_W'(OUT_W))) |=> line);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!rise && !upd && !load) |=> $stable(line));
endmodule

bind sdadc_serial_port sdadc_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .sample(sample_i), .sat(sat_w),
  .load(tick_w.load), .upd(tick_w.upd), .rise(rise_w),
  .ptr(ptr_w), .line(rdy_dout_o)
);

// File: tb/sim_sdadc_serial_port.sv
`timescale 1ns/1ps
module sim_sdadc_serial_port;
  localparam int IN_W = 32;
  localparam int CONV = 400;
  localparam int UPD  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0] samp = '0;
  logic sclk = 1'b0;
  logic line;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdadc_serial_port #(.IN_W(IN_W), .OUT_W(24), .CONV_CYC(CONV), .UPD_CYC(UPD)) u0 (
    .clk(clk), .rst(rst), .sample_i(samp), .sclk_i(sclk), .rdy_dout_o(line)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [23:0] sat_ref(input logic [IN_W-1:0] v);
    longint s;
    s = longint'($signed(v));
    if (s > 64'sd8388607) return 24'h7FFFFF;
    if (s < -64'sd8388608) return 24'h800000;
    return v[23:0];
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  int fall_t = 0;
  int hi_cnt = 0;
  task automatic wait_fall();
    while (line == 1'b0) tk(1);
    hi_cnt = 0;
    while (line == 1'b1) begin tk(1); hi_cnt++; end
    fall_t = cyc;
  endtask

  task automatic read_bits(input int n, input logic [23:0] w, input string tag);
    logic prev;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; tk(6);
      if (i < 24) chk({tag, " R5 bit"}, line, w[23-i]);
      else        chk("R7 extra edge high", line, 1);
      prev = line;
      sclk = 1'b0; tk(6);
      chk("R9 falling edge no effect", line, prev);
    end
  endtask

  logic [23:0] cur;
  int last_t;
  logic [31:0] r;
  int mode, k;

  initial begin
    sclk = 1'b0;
    samp = 32'h7FFF_FFFF;
    tk(5); rst = 1'b0; tk(2);
    chk("R1 reset line high", line, 1);
    sclk = 1'b1; tk(6); sclk = 1'b0; tk(6);
    sclk = 1'b1; tk(6); sclk = 1'b0; tk(6);
    chk("R1 edges before first result", line, 1);

    // first result: positive clip
    wait_fall(); last_t = fall_t;
    cur = sat_ref(samp);
    chk("R2 clip high", cur, 24'h7FFFFF);
    samp = 32'h8000_0000;
    read_bits(26, cur, "R2");
    chk("R7 still high after 26 edges", line, 1);

    // negative clip and period length
    wait_fall();
    chk("R4 period length", fall_t - last_t, CONV);
    last_t = fall_t;
    cur = sat_ref(samp);
    samp = 32'h0;
    read_bits(25, cur, "R3");

    // all-zero word: partial read, hold, window length, edge in window
    wait_fall();
    chk("R4 period length", fall_t - last_t, CONV);
    cur = sat_ref(samp);
    samp = 32'h0000_1234;
    read_bits(3, cur, "R3");
    tk(40);
    chk("R6 hold last bit", line, 0);
    while (line == 1'b0) tk(1);
    sclk = 1'b1; tk(3); sclk = 1'b0; tk(1);
    chk("R8 edge ignored in window", line, 1);
    wait_fall();
    cur = sat_ref(samp);
    samp = 32'hFFFF_FF00;
    read_bits(24, cur, "R8 msb after window");

    // partial read of zero tail, then window length
    wait_fall();
    cur = sat_ref(samp);
    chk("R3 in-range negative", cur, 24'hFFFF00);
    samp = 32'h0;
    read_bits(20, cur, "R3");
    tk(30);
    chk("R6 hold last bit", line, 0);
    wait_fall();
    chk("R8 high interval length", hi_cnt, UPD - 1);

    // unread result is overwritten
    cur = sat_ref(samp);
    samp = 32'h0055_AA33;
    wait_fall();
    cur = sat_ref(samp);
    samp = 32'h0012_3456;
    read_bits(24, cur, "R4 overwrite");

    // random periods
    for (int p = 0; p < 24; p++) begin
      wait_fall();
      cur = sat_ref(samp);
      r = $urandom();
      if (r[0]) samp = {{8{r[31]}}, r[31:8]};
      else      samp = $urandom();
      mode = $urandom_range(0, 2);
      if (mode == 0) begin
        read_bits(25, cur, "R5 rnd");
        chk("R7 high after 25", line, 1);
      end else if (mode == 1) begin
        k = $urandom_range(1, 23);
        read_bits(k, cur, "R5 rnd partial");
        tk(30);
        chk("R6 hold last bit", line, cur[24-k]);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1245));
  end
endmodule